// File: doc/BRIEF.md
# Double Bus Fault Halt Monitor

This block watches a processor's bus error line together with a few exception-processing status strobes. It decides when a bus error has struck at a moment the processor cannot recover from, which is a double bus fault. Three situations count as such a fault:

- the processor is still starting up after reset and has not yet executed its first instruction;
- bus error exception processing has begun and the first handler instruction has not yet been fetched;
- the processor is reading a bus error stack frame back while returning from an exception.

On a double fault the block drives an active-low halt output. Only a reset releases that output.

A single enable input selects what happens after the halt. With the enable set, the block raises a reset request for a fixed number of cycles, starting in the same cycle that halt goes low. With the enable clear, no request is raised, and the block stays halted until the external reset input is applied. A bus error that falls outside all three windows is treated as an ordinary, recoverable error and is ignored.

Top module: `dbf_halt_monitor`

## Requirements
- R1: While `rst_n` is low, and in the first cycle after it is released, `halt_n` is 1 and `rst_req` is 0.
- R2: The startup window is open from the release of reset up to and including the cycle in which `first_insn` is 1. A `bus_err` in any of those cycles drives `halt_n` to 0 at the next clock edge.
- R3: A `bus_err` in any cycle after the one in which `exc_start` is 1, up to and including the cycle in which `handler_fetch` is 1, drives `halt_n` to 0 at the next edge. A `bus_err` in the `exc_start` cycle itself is the first error and does not halt.
- R4: A `bus_err` in a cycle in which `rte_frame_load` is 1 drives `halt_n` to 0 at the next edge.
- R5: A `bus_err` that lies outside all three windows leaves `halt_n` at 1 and `rst_req` at 0.
- R6: Once `halt_n` is 0 it stays 0 until `rst_n` goes low. Bus errors and strobes that arrive while halted have no effect on either output.
- R7: If `hm_enable` is 1 in the cycle a fault is detected, `rst_req` goes to 1 in the same cycle that `halt_n` goes to 0. It stays 1 for exactly `RST_PULSE_CYCLES` cycles, and this happens only once per halt.
- R8: If `hm_enable` is 0 in the cycle a fault is detected, `rst_req` stays 0 for the whole halt.
- R9: Reset closes an open exception window. After a reset, a `bus_err` that follows `first_insn` and has no new `exc_start` does not halt.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | External reset, active low, synchronous |
| bus_err | input | 1 | Bus error seen this cycle |
| exc_start | input | 1 | Strobe: bus error exception processing begins |
| handler_fetch | input | 1 | Strobe: first handler instruction is fetched |
| first_insn | input | 1 | Strobe: first instruction after reset executes |
| rte_frame_load | input | 1 | Level: bus error stack frame is being reloaded |
| hm_enable | input | 1 | 1 selects auto-reset, 0 selects indefinite halt |
| halt_n | output | 1 | Halt, active low |
| rst_req | output | 1 | Reset request pulse |

## Verification
The edges of each window are the hardest cases to reach from the ports. These are a bus error in the very cycle that opens or closes a window, and a second error that arrives once the block is already halted. The bench sweeps the bus error position one cycle at a time across each window, from before it opens to after it closes. It runs every position with the enable both set and clear. For each halted run it also injects a further error inside the frame-reload window, so that any second request pulse would show up.

// File: rtl/dbf_halt_monitor.sv
module dbf_halt_monitor #(
  parameter int RST_PULSE_CYCLES = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic bus_err,
  input  logic exc_start,
  input  logic handler_fetch,
  input  logic first_insn,
  input  logic rte_frame_load,
  input  logic hm_enable,
  output logic halt_n,
  output logic rst_req
);
  localparam int CW = $clog2(RST_PULSE_CYCLES + 1);

  logic          startup_open;
  logic          exc_open;
  logic          halted;
  logic [CW-1:0] pulse_cnt;
  logic          fault;

  assign fault   = !halted && bus_err && (startup_open || exc_open || rte_frame_load);
  assign halt_n  = !halted;
  assign rst_req = (pulse_cnt != '0);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      startup_open <= 1'b1;
      exc_open     <= 1'b0;
    end else if (!halted) begin
      if (first_insn)         startup_open <= 1'b0;
      if (handler_fetch)      exc_open     <= 1'b0;
      else if (exc_start)     exc_open     <= 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      halted    <= 1'b0;
      pulse_cnt <= '0;
    end else if (fault) begin
      halted    <= 1'b1;
      pulse_cnt <= hm_enable ? CW'(RST_PULSE_CYCLES) : '0;
    end else if (pulse_cnt != '0) begin
      pulse_cnt <= pulse_cnt - 1'b1;
    end
  end
endmodule

module dbf_halt_monitor_chk #(
  parameter int RST_PULSE_CYCLES = 4
) (
  input logic clk,
  input logic rst_n,
  input logic bus_err,
  input logic rte_frame_load,
  input logic hm_enable,
  input logic halt_n,
  input logic rst_req
);
  localparam int CW = $clog2(RST_PULSE_CYCLES + 2);
  logic [CW-1:0] run_len;

  always_ff @(posedge clk) begin
    if (!rst_n)       run_len <= '0;
    else if (rst_req) run_len <= run_len + 1'b1;
    else              run_len <= '0;
  end

  AST_HALT_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    !halt_n |=> !halt_n);  // R6
  AST_REQ_NEEDS_HALT: assert property (@(posedge clk) disable iff (!rst_n)
    rst_req |-> !halt_n);  // R7
  AST_REQ_FOLLOWS_ENABLE: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(halt_n) |-> (rst_req == $past(hm_enable)));  // R8
  AST_RTE_HALTS: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_err && rte_frame_load) |=> !halt_n);  // R4
  AST_REQ_RISES_WITH_HALT: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_req) |-> $fell(halt_n));  // R7
  AST_PULSE_LENGTH: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(rst_req) |-> (run_len == CW'(RST_PULSE_CYCLES)));  // R7
endmodule

bind dbf_halt_monitor dbf_halt_monitor_chk #(.RST_PULSE_CYCLES(RST_PULSE_CYCLES)) chk_i (
  .clk(clk), .rst_n(rst_n), .bus_err(bus_err), .rte_frame_load(rte_frame_load),
  .hm_enable(hm_enable), .halt_n(halt_n), .rst_req(rst_req)
);

// File: tb/dbf_halt_monitor_tb_top.sv
module dbf_halt_monitor_tb_top;
  localparam int LEN = 4;

  logic clk = 1'b0;
  logic rst_n, bus_err, exc_start, handler_fetch, first_insn, rte_frame_load, hm_enable;
  logic halt_n, rst_req;
  int   checks = 0;
  int   fails  = 0;

  always #4 clk = ~clk;

  dbf_halt_monitor #(.RST_PULSE_CYCLES(LEN)) dut_i (
    .clk(clk), .rst_n(rst_n), .bus_err(bus_err), .exc_start(exc_start),
    .handler_fetch(handler_fetch), .first_insn(first_insn),
    .rte_frame_load(rte_frame_load), .hm_enable(hm_enable),
    .halt_n(halt_n), .rst_req(rst_req)
  );

  task automatic chk(input logic act, input logic exp, input string req, input string what);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s: actual %0b expected %0b at %0t", req, what, act, exp, $time);
    end
  endtask

  task automatic clear_inputs();
    bus_err = 0; exc_start = 0; handler_fetch = 0; first_insn = 0; rte_frame_load = 0;
  endtask

  task automatic do_reset();
    clear_inputs();
    rst_n = 0;
    repeat (2) @(posedge clk);
    #1;
    chk(halt_n, 1'b1, "R1", "halt_n in reset");
    chk(rst_req, 1'b0, "R1", "rst_req in reset");
    rst_n = 1;
  endtask

  // kind 0: startup (first_insn at c=3); 1: exception (first_insn c0, exc_start c2, handler_fetch c5)
  // kind 2: frame reload (first_insn c0, rte_frame_load c3..c5)
  task automatic run(input int kind, input int k, input logic en);
    logic fault;
    string req;
    int reqcnt;
    case (kind)
      0: begin fault = (k <= 3);            req = (k <= 3) ? "R2" : "R5"; end
      1: begin fault = (k >= 3 && k <= 5);  req = fault ? "R3" : "R5"; end
      default: begin fault = (k >= 3 && k <= 5); req = fault ? "R4" : "R5"; end
    endcase
    reqcnt = 0;
    do_reset();
    hm_enable = en;
    for (int c = 0; c < 18; c++) begin
      clear_inputs();
      case (kind)
        0: first_insn = (c == 3);
        1: begin first_insn = (c == 0); exc_start = (c == 2); handler_fetch = (c == 5); end
        default: begin first_insn = (c == 0); rte_frame_load = (c >= 3 && c <= 5); end
      endcase
      bus_err = (c == k);
      if (fault && c == k + 3) begin bus_err = 1; rte_frame_load = 1; exc_start = 1; end
      @(posedge clk);
      #1;
      if (rst_req) reqcnt++;
      if (c == k) begin
        chk(halt_n, !fault, req, "halt_n after bus error");
        chk(rst_req, fault && en, en ? "R7" : "R8", "rst_req with halt");
      end
      if (c == 17) begin
        chk(halt_n, !fault, fault ? "R6" : "R5", "halt_n held");
        chk(reqcnt == (fault && en ? LEN : 0), 1'b1, en ? "R7" : "R8", "rst_req cycle count");
      end
    end
  endtask

  initial begin
    #(8 * 200000);
    fails++;
    $display("FAIL watchdog expired");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    rst_n = 0; hm_enable = 0;
    clear_inputs();
    for (int en = 0; en < 2; en++) begin
      for (int k = 0; k < 10; k++) run(0, k, en[0]);
      for (int k = 1; k < 10; k++) run(1, k, en[0]);
      for (int k = 1; k < 10; k++) run(2, k, en[0]);
    end
    // R9: reset while exception window is open
    do_reset();
    hm_enable = 1;
    first_insn = 1; @(posedge clk); #1; clear_inputs();
    exc_start = 1;  @(posedge clk); #1; clear_inputs();
    rst_n = 0;      @(posedge clk); #1; rst_n = 1;
    first_insn = 1; @(posedge clk); #1; clear_inputs();
    bus_err = 1;    @(posedge clk); #1; clear_inputs();
    chk(halt_n, 1'b1, "R9", "halt_n after reset closed window");
    chk(rst_req, 1'b0, "R9", "rst_req after reset closed window");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule